// File: doc/BRIEF.md
# Mains-Derived One-Second Pulse Prescaler

This block derives a one-second timing pulse from the mains frequency. A digitised, active-low copy of the mains waveform enters the block, which runs on a fast system clock. The input is brought into the clock domain by a two-flop synchroniser, and its edges are turned into single-cycle enables. A 6-bit counter advances on every falling edge of the mains input. When the count reaches a programmable terminal value T, a hold state clears the counter and drives the active-low seconds pulse. The hold state ends at the next rising edge of the mains input. From there, counting starts again at zero. A full pulse period is therefore exactly T mains periods. For example, T = 50 gives one pulse per second on a 50 Hz supply.

The control is a two-state machine. In S_COUNT, the counter advances on falling mains edges and the pulse output is high. In S_HOLD, the counter is held at zero and the pulse output is low. There are two transitions. S_COUNT goes to S_HOLD on the falling edge that completes T periods (the "terminal" transition). S_HOLD goes to S_COUNT on the next rising mains edge (the "release" transition). The master clear forces S_COUNT from any state. Terminal values 0 and 1 both act as T = 1.

Top module: `mains_pps_prescaler`

## Requirements
- R1: While master clear is high and after it falls, the count is 0 and the pulse output is high (1).
- R2: In S_COUNT, each 1-to-0 transition of the mains input adds one to the count, three clock edges after the input changes. A 0-to-1 transition in S_COUNT leaves the count unchanged.
- R3: On the falling mains edge that would bring the count to T, the count becomes 0 and the pulse output goes low in the same clock cycle (terminal transition). The count never shows the value T.
- R4: In S_HOLD, the pulse output stays low and the count stays 0 until the next rising mains edge. Three clock edges after that rise, the pulse output returns high (release transition).
- R5: After release, the next falling mains edge gives a count of 1. Consecutive pulses are exactly T mains periods apart.
- R6: A terminal input of 0 or 1 acts as T = 1: one pulse per mains period, with the count always 0 after release.
- R7: If the terminal input is lowered to a value at or below count+1, the next falling mains edge is treated as terminal.
- R8: A terminal input of 63 gives one pulse every 63 mains periods, with a largest count of 62.
- R9: Master clear during S_HOLD returns the pulse output high and the count to 0 at the next clock edge. Counting resumes from 0 at the next falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, much faster than the mains |
| mclr_i | input | 1 | Master clear, active high, asynchronous |
| mains_n_i | input | 1 | Digitised mains waveform, active low |
| term_cnt_i | input | 6 | Terminal count T (0 and 1 act as 1) |
| count_o | output | 6 | Current mains-period count |
| pps_n_o | output | 1 | Seconds pulse, active low, low while in S_HOLD |

## Verification
A change on the mains input takes three rising clock edges to show at the outputs: two synchroniser stages and one state or counter update. A master clear takes effect at once and holds. Every bench task drives the mains input at a falling clock edge and then waits six cycles before sampling at a falling edge. Each sample therefore sees the settled result of exactly one mains edge. Pulse periods are measured by counting high-to-low steps of the pulse output at falling clock edges, across runs of whole mains periods.

// File: rtl/pps_pkg.sv
package pps_pkg;
    typedef enum logic {
        S_COUNT = 1'b0,
        S_HOLD  = 1'b1
    } pps_state_t;
endpackage

// File: rtl/mains_edge_det.sv
module mains_edge_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic mclr_i,
    input  logic mains_n_i,
    output logic fall_en_o,
    output logic rise_en_o
);
    // pipe[0..SYNC_STAGES-1] synchronise, pipe[SYNC_STAGES] keeps the previous sample
    logic [SYNC_STAGES:0] pipe;

    for (genvar g = 0; g <= SYNC_STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk_i or posedge mclr_i) begin
                if (mclr_i) pipe[g] <= 1'b0;
                else        pipe[g] <= mains_n_i;
            end
        end else begin : g_next
            always_ff @(posedge clk_i or posedge mclr_i) begin
                if (mclr_i) pipe[g] <= 1'b0;
                else        pipe[g] <= pipe[g-1];
            end
        end
    end

    always_comb begin
        fall_en_o = pipe[SYNC_STAGES] & ~pipe[SYNC_STAGES-1];
        rise_en_o = ~pipe[SYNC_STAGES] & pipe[SYNC_STAGES-1];
    end
endmodule

// File: rtl/pps_count_unit.sv
module pps_count_unit #(
    parameter int CNT_W = 6
) (
    input  logic             clk_i,
    input  logic             mclr_i,
    input  logic             adv_i,
    input  logic             hold_i,
    input  logic [CNT_W-1:0] term_i,
    output logic [CNT_W-1:0] count_o,
    output logic             hit_o
);
    localparam int EXT_W = CNT_W + 1;

    logic [CNT_W-1:0] eff_term;
    logic [EXT_W-1:0] next_val;

    always_comb begin
        eff_term = (term_i < CNT_W'(2)) ? CNT_W'(1) : term_i;
        next_val = {1'b0, count_o} + EXT_W'(1);
        hit_o    = adv_i && (next_val >= {1'b0, eff_term});
    end

    always_ff @(posedge clk_i or posedge mclr_i) begin
        if (mclr_i)               count_o <= '0;
        else if (hold_i || hit_o) count_o <= '0;
        else if (adv_i)           count_o <= next_val[CNT_W-1:0];
    end
endmodule

// File: rtl/pps_hold_fsm.sv
module pps_hold_fsm
    import pps_pkg::*;
(
    input  logic clk_i,
    input  logic mclr_i,
    input  logic hit_i,
    input  logic rise_i,
    output logic pps_n_o,
    output logic holding_o
);
    pps_state_t state_q, state_d;

    always_ff @(posedge clk_i or posedge mclr_i) begin
        if (mclr_i) state_q <= S_COUNT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_COUNT: if (hit_i)  state_d = S_HOLD;
            S_HOLD:  if (rise_i) state_d = S_COUNT;
            default: state_d = S_COUNT;
        endcase
    end

    always_comb begin
        holding_o = (state_q == S_HOLD);
        pps_n_o   = (state_q != S_HOLD);
    end
endmodule

// File: rtl/mains_pps_prescaler.sv
module mains_pps_prescaler #(
    parameter int CNT_W       = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             mclr_i,
    input  logic             mains_n_i,
    input  logic [CNT_W-1:0] term_cnt_i,
    output logic [CNT_W-1:0] count_o,
    output logic             pps_n_o
);
    logic fall_en, rise_en, hit, holding, adv;

    mains_edge_det #(.SYNC_STAGES(SYNC_STAGES)) edge_i (
        .clk_i(clk_i), .mclr_i(mclr_i), .mains_n_i(mains_n_i),
        .fall_en_o(fall_en), .rise_en_o(rise_en)
    );

    assign adv = fall_en & ~holding;

    pps_count_unit #(.CNT_W(CNT_W)) cnt_i (
        .clk_i(clk_i), .mclr_i(mclr_i), .adv_i(adv), .hold_i(holding),
        .term_i(term_cnt_i), .count_o(count_o), .hit_o(hit)
    );

    pps_hold_fsm fsm_i (
        .clk_i(clk_i), .mclr_i(mclr_i), .hit_i(hit), .rise_i(rise_en),
        .pps_n_o(pps_n_o), .holding_o(holding)
    );
endmodule

// File: rtl/pps_prescaler_chk.sv
module pps_prescaler_chk #(
    parameter int CNT_W = 6
) (
    input logic             clk_i,
    input logic             mclr_i,
    input logic             fall_en,
    input logic             rise_en,
    input logic [CNT_W-1:0] count_o,
    input logic             pps_n_o
);
    // R4
    hold_zero_chk: assert property (@(posedge clk_i) disable iff (mclr_i)
        !pps_n_o |-> count_o == '0);

    // R2
    count_step_chk: assert property (@(posedge clk_i) disable iff (mclr_i)
        (count_o != $past(count_o)) |->
            ((count_o == $past(count_o) + CNT_W'(1)) || (count_o == '0)));

    // R2
    rise_no_count_chk: assert property (@(posedge clk_i) disable iff (mclr_i)
        (rise_en && pps_n_o) |=> $stable(count_o));

    // R3
    pulse_start_chk: assert property (@(posedge clk_i) disable iff (mclr_i)
        $fell(pps_n_o) |-> ($past(fall_en) && count_o == '0));

    // R4
    pulse_end_chk: assert property (@(posedge clk_i) disable iff (mclr_i)
        $rose(pps_n_o) |-> $past(rise_en));
endmodule

bind mains_pps_prescaler pps_prescaler_chk #(.CNT_W(CNT_W)) chk_i (
    .clk_i(clk_i), .mclr_i(mclr_i), .fall_en(fall_en), .rise_en(rise_en),
    .count_o(count_o), .pps_n_o(pps_n_o)
);

// File: tb/mains_pps_prescaler_tb_top.sv
`timescale 1ns/1ps
module mains_pps_prescaler_tb_top;
    logic       clk = 1'b0;
    logic       mclr = 1'b1;
    logic       mains_n = 1'b0;
    logic [5:0] term = 6'd5;
    logic [5:0] count;
    logic       pps_n;
    int checks = 0;
    int failures = 0;
    int pulses = 0;
    logic pps_prev = 1'b1;

    always #2 clk = ~clk;

    mains_pps_prescaler dut_i (
        .clk_i(clk), .mclr_i(mclr), .mains_n_i(mains_n),
        .term_cnt_i(term), .count_o(count), .pps_n_o(pps_n)
    );

    always @(negedge clk) begin
        if (pps_prev && !pps_n) pulses++;
        pps_prev <= pps_n;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_mains(input logic v);
        @(negedge clk) mains_n = v;
        repeat (6) @(negedge clk);
    endtask

    task automatic do_clear();
        @(negedge clk) mclr = 1'b1;
        mains_n = 1'b0;
        repeat (4) @(negedge clk);
        mclr = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 count in clear", int'(count), 0);
        check("R1 pulse in clear", int'(pps_n), 1);
        mclr = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 count after clear", int'(count), 0);
        check("R1 pulse after clear", int'(pps_n), 1);
    endtask

    task automatic t_basic();
        do_clear();
        term = 6'd5;
        for (int i = 1; i <= 4; i++) begin
            set_mains(1'b1);
            check("R2 rise keeps count", int'(count), i - 1);
            set_mains(1'b0);
            check("R2 fall increments", int'(count), i);
        end
        set_mains(1'b1);
        set_mains(1'b0);
        check("R3 terminal count zero", int'(count), 0);
        check("R3 pulse low", int'(pps_n), 0);
        repeat (20) @(negedge clk);
        check("R4 pulse held low", int'(pps_n), 0);
        check("R4 count held zero", int'(count), 0);
        set_mains(1'b1);
        check("R4 pulse released", int'(pps_n), 1);
        check("R4 count after release", int'(count), 0);
        set_mains(1'b0);
        check("R5 first count after release", int'(count), 1);
    endtask

    task automatic t_period(input int t, input int n, input string req);
        int p0;
        int mx = 0;
        do_clear();
        term = 6'(t);
        p0 = pulses;
        for (int i = 0; i < n * t; i++) begin
            set_mains(1'b1);
            set_mains(1'b0);
            if (int'(count) > mx) mx = int'(count);
        end
        check({req, " pulse count"}, pulses - p0, n);
        check({req, " pulse low at end"}, int'(pps_n), 0);
        check({req, " largest count"}, mx, t - 1);
    endtask

    task automatic t_small(input int t);
        int p0;
        do_clear();
        term = 6'(t);
        p0 = pulses;
        for (int i = 0; i < 4; i++) begin
            set_mains(1'b1);
            check("R6 count zero after release", int'(count), 0);
            check("R6 pulse high after release", int'(pps_n), 1);
            set_mains(1'b0);
            check("R6 pulse every period", int'(pps_n), 0);
        end
        check("R6 pulses in four periods", pulses - p0, 4);
    endtask

    task automatic t_lower();
        do_clear();
        term = 6'd20;
        for (int i = 0; i < 10; i++) begin
            set_mains(1'b1);
            set_mains(1'b0);
        end
        check("R7 count before lowering", int'(count), 10);
        term = 6'd4;
        set_mains(1'b1);
        check("R7 no pulse before fall", int'(pps_n), 1);
        set_mains(1'b0);
        check("R7 lowered terminal pulse", int'(pps_n), 0);
        check("R7 lowered terminal count", int'(count), 0);
    endtask

    task automatic t_mclr();
        do_clear();
        term = 6'd3;
        for (int i = 0; i < 3; i++) begin
            set_mains(1'b1);
            set_mains(1'b0);
        end
        check("R9 in hold before clear", int'(pps_n), 0);
        @(negedge clk) mclr = 1'b1;
        @(negedge clk);
        check("R9 clear releases pulse", int'(pps_n), 1);
        check("R9 clear zeroes count", int'(count), 0);
        mclr = 1'b0;
        set_mains(1'b1);
        set_mains(1'b0);
        check("R9 count resumes", int'(count), 1);
    endtask

    initial begin
        #400000;
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_period(50, 3, "R5");
        t_period(63, 2, "R8");
        t_small(0);
        t_small(1);
        t_lower();
        t_mclr();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule